// File: doc/BRIEF.md
# Dual-Write-Port Register File

This block is a general-purpose register file for a pipelined core that must retire instructions touching two registers in a single cycle. Examples are an exchange of two registers, or an add-immediate applied to a consecutive register pair. It holds 32 entries of 64 bits. Two combinational read ports serve the decode stage, and two independent synchronous write ports serve write-back.

A value committed by either write port is returned by a read of the same address in the same cycle. The decode stage therefore never needs an inverted clock or an extra bubble to see a result being written back. If both write ports target one register, the result is deterministic: the first port wins, in storage and on the read bypass. Entry 0 is hard-wired to zero.

For an exchange, the surrounding datapath reads both old values through the two read ports. It then feeds them crosswise into the write ports in the same cycle. The datapath captures those old values before the writes assert, so the bypass does not loop them back.

Top module: `dual_wr_regfile`

## Requirements
- R1: While the synchronous, active-high reset is sampled high at a rising edge, every entry is cleared to zero, and any write in that cycle is dropped.
- R2: When write port 1 is enabled at a rising edge, its data is stored in the entry named by its 5-bit address. Later reads of that address return the data.
- R3: When write port 2 is enabled at a rising edge and port 1 does not target the same entry, its data is stored in the entry named by its address.
- R4: Both write ports may commit to different entries in the same edge, as in a pair update of register n through port 1 and register n+1 through port 2.
- R5: If both write ports are enabled and target the same entry, port 1's data is stored and port 2's data is discarded.
- R6: Address 0 always reads as zero on both read ports, including in the cycle of a write to it. Writes to address 0 from either port leave it at zero.
- R7: On read port X, if an enabled write port targets the read address (other than 0) in the current cycle, that write data is returned in the same cycle instead of the stored value.
- R8: Read port Y has the same same-cycle visibility as R7, for writes from either port.
- R9: When both write ports target the read address in the same cycle, a read returns port 1's data.
- R10: An exchange of registers a and b exchanges their contents in one edge. The exchange writes port 1 to a with the old value of b and port 2 to b with the old value of a. An exchange of a register with itself leaves its value unchanged.
- R11: A write port whose enable is low changes no entry and alters no read result, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | 5 | Write port 1 destination entry |
| wr1_data | input | 64 | Write port 1 data |
| wr2_en | input | 1 | Write port 2 enable |
| wr2_addr | input | 5 | Write port 2 destination entry |
| wr2_data | input | 64 | Write port 2 data |
| rdx_addr | input | 5 | Read port X address |
| rdx_data | output | 64 | Read port X data (combinational, write-through) |
| rdy_addr | input | 5 | Read port Y address |
| rdy_data | output | 64 | Read port Y data (combinational, write-through) |

## Verification
The assertions assume that every control and address input is a known value at each rising edge while reset is low. They also assume that write data is never derived combinationally from the read outputs in the same cycle, since that would close a loop through the bypass. The commit properties assume that a read in the following cycle is not itself hit by a new write. The property only checks in that case. The bench drives all inputs from the falling edge with defined values. For exchanges, it captures the old read values into bench variables before raising the write enables, which keeps every write-data input independent of the read outputs.

// File: rtl/rf_pkg.sv
package rf_pkg;

   // Source selected for one read port in one cycle
   typedef enum logic [1:0] {
      RF_SRC_STORE = 2'd0,
      RF_SRC_WP1   = 2'd1,
      RF_SRC_WP2   = 2'd2,
      RF_SRC_ZERO  = 2'd3
   } rf_src_e;

   // Ordering: hard zero, then port 1, then port 2, then stored entry
   function automatic rf_src_e rf_pick_src(input logic is_zero,
                                           input logic hit1,
                                           input logic hit2);
      rf_src_e s;
      if (is_zero)   s = RF_SRC_ZERO;
      else if (hit1) s = RF_SRC_WP1;
      else if (hit2) s = RF_SRC_WP2;
      else           s = RF_SRC_STORE;
      return s;
   endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 64,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input  logic                             wr1_en,
   input  logic [AW-1:0]                    wr1_addr,
   input  logic [DATA_W-1:0]                wr1_data,
   input  logic                             wr2_en,
   input  logic [AW-1:0]                    wr2_addr,
   input  logic [DATA_W-1:0]                wr2_data,
   output logic [NUM_REGS-1:0]              ent_en,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  ent_dat
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      if (ZERO_REG && i == 0) begin : g_hard_zero
         assign ent_en[i]  = 1'b0;
         assign ent_dat[i] = '0;
      end else begin : g_live
         logic hit1, hit2;
         assign hit1       = wr1_en && (wr1_addr == AW'(i));
         assign hit2       = wr2_en && (wr2_addr == AW'(i));
         assign ent_en[i]  = hit1 || hit2;
         // port 1 takes the entry on a collision
         assign ent_dat[i] = hit1 ? wr1_data : wr2_data;
      end
   end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 64,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_REGS-1:0]              ent_en,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  ent_dat,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  ent_q
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      if (ZERO_REG && i == 0) begin : g_tie
         assign ent_q[i] = '0;
      end else begin : g_flop
         always_ff @(posedge clk) begin
            if (rst)            ent_q[i] <= '0;
            else if (ent_en[i]) ent_q[i] <= ent_dat[i];
         end
      end
   end

endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
   import rf_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 64,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input  logic [AW-1:0]                    rd_addr,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  ent_q,
   input  logic                             wr1_en,
   input  logic [AW-1:0]                    wr1_addr,
   input  logic [DATA_W-1:0]                wr1_data,
   input  logic                             wr2_en,
   input  logic [AW-1:0]                    wr2_addr,
   input  logic [DATA_W-1:0]                wr2_data,
   output logic [DATA_W-1:0]                rd_data
);

   logic    is_zero, hit1, hit2;
   rf_src_e src;

   if (ZERO_REG) begin : g_zero_chk
      assign is_zero = (rd_addr == '0);
   end else begin : g_no_zero
      assign is_zero = 1'b0;
   end

   assign hit1 = wr1_en && (wr1_addr == rd_addr);
   assign hit2 = wr2_en && (wr2_addr == rd_addr);
   assign src  = rf_pick_src(is_zero, hit1, hit2);

   always_comb begin
      unique case (src)
         RF_SRC_WP1:   rd_data = wr1_data;
         RF_SRC_WP2:   rd_data = wr2_data;
         RF_SRC_ZERO:  rd_data = '0;
         default:      rd_data = ent_q[rd_addr];
      endcase
   end

endmodule

// File: rtl/dual_wr_regfile.sv
module dual_wr_regfile #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 64,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr1_en,
   input  logic [AW-1:0]     wr1_addr,
   input  logic [DATA_W-1:0] wr1_data,
   input  logic              wr2_en,
   input  logic [AW-1:0]     wr2_addr,
   input  logic [DATA_W-1:0] wr2_data,
   input  logic [AW-1:0]     rdx_addr,
   output logic [DATA_W-1:0] rdx_data,
   input  logic [AW-1:0]     rdy_addr,
   output logic [DATA_W-1:0] rdy_data
);

   if (NUM_REGS < 2 || (1 << AW) != NUM_REGS) begin : g_bad_depth
      $error("dual_wr_regfile: NUM_REGS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dual_wr_regfile: DATA_W must be positive");
   end

   logic [NUM_REGS-1:0]             ent_en;
   logic [NUM_REGS-1:0][DATA_W-1:0] ent_dat;
   logic [NUM_REGS-1:0][DATA_W-1:0] ent_q;

   rf_wr_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ZERO_REG(ZERO_REG)) u_dec (
      .wr1_en   (wr1_en),
      .wr1_addr (wr1_addr),
      .wr1_data (wr1_data),
      .wr2_en   (wr2_en),
      .wr2_addr (wr2_addr),
      .wr2_data (wr2_data),
      .ent_en   (ent_en),
      .ent_dat  (ent_dat)
   );

   rf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ZERO_REG(ZERO_REG)) u_store (
      .clk     (clk),
      .rst     (rst),
      .ent_en  (ent_en),
      .ent_dat (ent_dat),
      .ent_q   (ent_q)
   );

   rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ZERO_REG(ZERO_REG)) u_rdx (
      .rd_addr  (rdx_addr),
      .ent_q    (ent_q),
      .wr1_en   (wr1_en),
      .wr1_addr (wr1_addr),
      .wr1_data (wr1_data),
      .wr2_en   (wr2_en),
      .wr2_addr (wr2_addr),
      .wr2_data (wr2_data),
      .rd_data  (rdx_data)
   );

   rf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ZERO_REG(ZERO_REG)) u_rdy (
      .rd_addr  (rdy_addr),
      .ent_q    (ent_q),
      .wr1_en   (wr1_en),
      .wr1_addr (wr1_addr),
      .wr1_data (wr1_data),
      .wr2_en   (wr2_en),
      .wr2_addr (wr2_addr),
      .wr2_data (wr2_data),
      .rd_data  (rdy_data)
   );

endmodule

// File: rtl/dual_wr_regfile_chk.sv
module dual_wr_regfile_chk #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 64,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input logic              clk,
   input logic              rst,
   input logic              wr1_en,
   input logic [AW-1:0]     wr1_addr,
   input logic [DATA_W-1:0] wr1_data,
   input logic              wr2_en,
   input logic [AW-1:0]     wr2_addr,
   input logic [DATA_W-1:0] wr2_data,
   input logic [AW-1:0]     rdx_addr,
   input logic [DATA_W-1:0] rdx_data,
   input logic [AW-1:0]     rdy_addr,
   input logic [DATA_W-1:0] rdy_data
);

   logic hit_x, hit_y, nz_x, nz_y, nz_w1, nz_w2;
   assign hit_x = (wr1_en && wr1_addr == rdx_addr) || (wr2_en && wr2_addr == rdx_addr);
   assign hit_y = (wr1_en && wr1_addr == rdy_addr) || (wr2_en && wr2_addr == rdy_addr);
   assign nz_x  = !ZERO_REG || (rdx_addr != '0);
   assign nz_y  = !ZERO_REG || (rdy_addr != '0);
   assign nz_w1 = !ZERO_REG || (wr1_addr != '0);
   assign nz_w2 = !ZERO_REG || (wr2_addr != '0);

   // R1: after a reset edge, unwritten entries read zero
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (rst || hit_x || rdx_data == '0));

   // R2 and R5: port 1 data lands in storage, even on a collision
   p_commit_wp1_r2: assert property (@(posedge clk) disable iff (rst)
      (wr1_en && nz_w1) ##1 (rdx_addr == $past(wr1_addr) && !hit_x)
      |-> rdx_data == $past(wr1_data));

   // R3: port 2 data lands when port 1 does not claim the entry
   p_commit_wp2_r3: assert property (@(posedge clk) disable iff (rst)
      (wr2_en && nz_w2 && !(wr1_en && wr1_addr == wr2_addr))
      ##1 (rdy_addr == $past(wr2_addr) && !hit_y)
      |-> rdy_data == $past(wr2_data));

   // R6: address zero reads zero on both ports
   p_zero_read_r6: assert property (@(posedge clk) disable iff (rst)
      (ZERO_REG && rdx_addr == '0) |-> (rdx_data == '0 && (rdy_addr != '0 || rdy_data == '0)));

   // R7 and R9: port 1 write is visible on read port X in the same cycle
   p_bypass_x_r7: assert property (@(posedge clk) disable iff (rst)
      (wr1_en && wr1_addr == rdx_addr && nz_x) |-> rdx_data == wr1_data);

   // R8: port 2 write is visible on read port Y when port 1 misses it
   p_bypass_y_r8: assert property (@(posedge clk) disable iff (rst)
      (wr2_en && wr2_addr == rdy_addr && !(wr1_en && wr1_addr == rdy_addr) && nz_y)
      |-> rdy_data == wr2_data);

   // R11: with no write in flight the read value holds across an edge
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!wr1_en && !wr2_en) ##1 ($stable(rdx_addr) && !hit_x && !$past(rst))
      |-> $stable(rdx_data));

endmodule

bind dual_wr_regfile dual_wr_regfile_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .ZERO_REG (ZERO_REG)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr1_en   (wr1_en),
   .wr1_addr (wr1_addr),
   .wr1_data (wr1_data),
   .wr2_en   (wr2_en),
   .wr2_addr (wr2_addr),
   .wr2_data (wr2_data),
   .rdx_addr (rdx_addr),
   .rdx_data (rdx_data),
   .rdy_addr (rdy_addr),
   .rdy_data (rdy_data)
);

// File: tb/dual_wr_regfile_tb_top.sv
module dual_wr_regfile_tb_top;

   localparam int NR = 32;
   localparam int DW = 64;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr1_en = 1'b0, wr2_en = 1'b0;
   logic [AW-1:0] wr1_addr = '0, wr2_addr = '0, rdx_addr = '0, rdy_addr = '0;
   logic [DW-1:0] wr1_data = '0, wr2_data = '0;
   logic [DW-1:0] rdx_data, rdy_data;

   logic [DW-1:0] model [NR];
   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   dual_wr_regfile dut_i (
      .clk(clk), .rst(rst),
      .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
      .wr2_en(wr2_en), .wr2_addr(wr2_addr), .wr2_data(wr2_data),
      .rdx_addr(rdx_addr), .rdx_data(rdx_data),
      .rdy_addr(rdy_addr), .rdy_data(rdy_data)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One edge with the given writes, then writes released; model follows R5/R6
   task automatic wr_cycle(input logic e1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                           input logic e2, input logic [AW-1:0] a2, input logic [DW-1:0] d2);
      @(negedge clk);
      wr1_en = e1; wr1_addr = a1; wr1_data = d1;
      wr2_en = e2; wr2_addr = a2; wr2_data = d2;
      @(posedge clk);
      if (e2 && a2 != 0 && !(e1 && a1 == a2)) model[a2] = d2;
      if (e1 && a1 != 0) model[a1] = d1;
      @(negedge clk);
      wr1_en = 1'b0; wr2_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a);
      @(negedge clk);
      rdx_addr = a; rdy_addr = a;
      #1;
      chk(req, rdx_data, model[a]);
      chk(req, rdy_data, model[a]);
   endtask

   task automatic t_reset_r1();
      for (int i = 0; i < NR; i++) model[i] = '0;
      rst = 1'b1;
      wr_cycle(1'b1, 5'd3, 64'hDEAD_0000_0000_0003, 1'b0, '0, '0);
      model[3] = '0;   // dropped under reset
      @(negedge clk); rst = 1'b0;
      rd_chk("R1", 5'd3);
      rd_chk("R1", 5'd31);
   endtask

   task automatic t_single_r2_r3();
      wr_cycle(1'b1, 5'd4, 64'h1111_2222_3333_4444, 1'b0, '0, '0);
      rd_chk("R2", 5'd4);
      wr_cycle(1'b0, '0, '0, 1'b1, 5'd31, 64'h8000_0000_0000_0001);
      rd_chk("R3", 5'd31);
   endtask

   task automatic t_pair_r4();
      wr_cycle(1'b1, 5'd10, 64'h0A0A_0A0A_0000_0010, 1'b1, 5'd11, 64'h0B0B_0B0B_0000_0011);
      rd_chk("R4", 5'd10);
      rd_chk("R4", 5'd11);
   endtask

   task automatic t_collision_r5();
      wr_cycle(1'b1, 5'd20, 64'h5555_0000_0000_0001, 1'b1, 5'd20, 64'hAAAA_0000_0000_0002);
      chk("R5", model[20], 64'h5555_0000_0000_0001);
      rd_chk("R5", 5'd20);
   endtask

   task automatic t_x0_r6();
      @(negedge clk);
      wr1_en = 1'b1; wr1_addr = '0; wr1_data = '1;
      wr2_en = 1'b1; wr2_addr = '0; wr2_data = 64'h1234;
      rdx_addr = '0; rdy_addr = '0;
      #1;
      chk("R6", rdx_data, '0);
      chk("R6", rdy_data, '0);
      @(negedge clk); wr1_en = 1'b0; wr2_en = 1'b0;
      rd_chk("R6", 5'd0);
   endtask

   task automatic t_bypass_r7_r8();
      @(negedge clk);
      wr1_en = 1'b1; wr1_addr = 5'd12; wr1_data = 64'hC0FF_EE00_0000_0012;
      wr2_en = 1'b1; wr2_addr = 5'd13; wr2_data = 64'hBEEF_0000_0000_0013;
      rdx_addr = 5'd12; rdy_addr = 5'd13;
      #1;
      chk("R7", rdx_data, 64'hC0FF_EE00_0000_0012);
      chk("R8", rdy_data, 64'hBEEF_0000_0000_0013);
      rdx_addr = 5'd13; rdy_addr = 5'd12;
      #0.5;
      chk("R7", rdx_data, 64'hBEEF_0000_0000_0013);
      chk("R8", rdy_data, 64'hC0FF_EE00_0000_0012);
      @(posedge clk);
      model[12] = 64'hC0FF_EE00_0000_0012;
      model[13] = 64'hBEEF_0000_0000_0013;
      @(negedge clk); wr1_en = 1'b0; wr2_en = 1'b0;
      rd_chk("R8", 5'd13);
   endtask

   task automatic t_priority_r9();
      @(negedge clk);
      wr1_en = 1'b1; wr1_addr = 5'd14; wr1_data = 64'h0000_0000_0000_0111;
      wr2_en = 1'b1; wr2_addr = 5'd14; wr2_data = 64'h0000_0000_0000_0222;
      rdx_addr = 5'd14; rdy_addr = 5'd14;
      #1;
      chk("R9", rdx_data, 64'h0000_0000_0000_0111);
      chk("R9", rdy_data, 64'h0000_0000_0000_0111);
      @(posedge clk); model[14] = 64'h0000_0000_0000_0111;
      @(negedge clk); wr1_en = 1'b0; wr2_en = 1'b0;
   endtask

   task automatic t_swap_r10(input logic [AW-1:0] a, input logic [AW-1:0] b);
      logic [DW-1:0] old_a, old_b;
      @(negedge clk);
      rdx_addr = a; rdy_addr = b;
      #1;
      old_a = rdx_data; old_b = rdy_data;
      wr1_en = 1'b1; wr1_addr = a; wr1_data = old_b;
      wr2_en = 1'b1; wr2_addr = b; wr2_data = old_a;
      @(posedge clk);
      @(negedge clk); wr1_en = 1'b0; wr2_en = 1'b0;
      rdx_addr = a; rdy_addr = b;
      #1;
      chk("R10", rdx_data, model[b]);
      chk("R10", rdy_data, model[a]);
      model[a] = old_b; model[b] = old_a;
   endtask

   task automatic t_disabled_r11();
      @(negedge clk);
      wr1_en = 1'b0; wr1_addr = 5'd4; wr1_data = '1;
      wr2_en = 1'b0; wr2_addr = 5'd10; wr2_data = '1;
      rdx_addr = 5'd4; rdy_addr = 5'd10;
      #1;
      chk("R11", rdx_data, model[4]);
      chk("R11", rdy_data, model[10]);
      @(posedge clk);
      rd_chk("R11", 5'd4);
      rd_chk("R11", 5'd10);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      t_reset_r1();
      t_single_r2_r3();
      t_pair_r4();
      t_collision_r5();
      t_x0_r6();
      t_bypass_r7_r8();
      t_priority_r9();
      wr_cycle(1'b1, 5'd5, 64'h0000_0000_0000_AAAA, 1'b1, 5'd9, 64'h0000_0000_0000_BBBB);
      t_swap_r10(5'd5, 5'd9);
      rd_chk("R10", 5'd5);
      rd_chk("R10", 5'd9);
      wr_cycle(1'b1, 5'd7, 64'h7777_0000_0000_0007, 1'b0, '0, '0);
      t_swap_r10(5'd7, 5'd7);
      rd_chk("R10", 5'd7);
      t_disabled_r11();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule